// File: doc/BRIEF.md
# Packed Integer Subtract Unit with Byte Saturation

This block subtracts one 128-bit operand from another lane by lane, as a SIMD datapath would. A two-bit width code divides the word into sixteen byte lanes, four 32-bit lanes or two 64-bit lanes. Each lane of the second operand is subtracted from the same lane of the first operand, and the difference goes to the same lane of the result. One chain of byte-wide subtract slices serves every width. The borrow between two slices is cut wherever a lane starts.

In byte mode a saturate input turns on signed saturating arithmetic. A difference that does not fit in a signed byte is clamped to the nearest limit instead of wrapping. At any other width the saturate input has no effect. The unit produces no status flags. The result is registered, so it appears on the clock edge after the operands are presented.

Top module: `lane_sub_unit`

## Requirements
- R1: A synchronous active-high reset clears `res_o` to zero. Otherwise `res_o` holds, one clock later, the result for the inputs sampled at the previous rising edge.
- R2: With `width_i` = 2'b00 and `sat_i` = 0, each byte lane k (bits 8k+7..8k) of `res_o` is (a − b) mod 256 of that lane.
- R3: With `width_i` = 2'b10, each 32-bit lane k (bits 32k+31..32k) is (a − b) mod 2^32.
- R4: With `width_i` = 2'b11, each 64-bit lane k (bits 64k+63..64k) is (a − b) mod 2^64.
- R5: No borrow crosses a lane boundary of the selected width. An all-zero first operand minus an all-ones second operand gives the value 1 in every lane.
- R6: With `width_i` = 2'b00 and `sat_i` = 1, a signed byte difference above +127 gives 8'h7F.
- R7: With `width_i` = 2'b00 and `sat_i` = 1, a signed byte difference below −128 gives 8'h80.
- R8: With `width_i` = 2'b00 and `sat_i` = 1, a signed byte difference within −128..+127 is output exactly.
- R9: With `width_i` = 2'b10 or 2'b11, `sat_i` = 1 gives the same wrapping result as `sat_i` = 0.
- R10: The reserved width code 2'b01 gives an all-zero result, whatever the operands and `sat_i`.
- R11: With any non-reserved width, equal operands give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 128 | First operand (minuend) |
| b_i | input | 128 | Second operand (subtrahend) |
| width_i | input | 2 | Lane width code: 00 byte, 10 32-bit, 11 64-bit, 01 reserved |
| sat_i | input | 1 | Signed saturation enable (acts in byte mode only) |
| res_o | output | 128 | Registered packed difference |

## Verification
The assertions assume that every input is a known value at each rising edge once reset is released, and that each result is compared against the inputs of the edge just before it. The bench meets this by driving every input on the falling edge and holding it for a full cycle, and by sampling `res_o` only on the falling edge after the capturing edge. The sign-based saturation properties assume only that the width code and `sat_i` are steady at the sampling edge. They hold for any operand values, so the exhaustive byte-pair sweep and the random wide-lane vectors stay inside them.

// File: rtl/lane_sub_pkg.sv
package lane_sub_pkg;
  typedef enum logic [1:0] {
    LW_8   = 2'b00,
    LW_RSV = 2'b01,
    LW_32  = 2'b10,
    LW_64  = 2'b11
  } lane_w_e;
endpackage

// File: rtl/lane_sub_slice.sv
// One byte-wide (SLICE_W) subtract slice with a borrow in and a borrow out.
module lane_sub_slice #(
  parameter int SLICE_W = 8
) (
  input  logic [SLICE_W-1:0] a_i,
  input  logic [SLICE_W-1:0] b_i,
  input  logic               bin_i,
  output logic [SLICE_W-1:0] diff_o,
  output logic               bout_o
);
  logic [SLICE_W:0] ext;

  always_comb begin
    ext    = {1'b0, a_i} - {1'b0, b_i} - {{SLICE_W{1'b0}}, bin_i};
    diff_o = ext[SLICE_W-1:0];
    bout_o = ext[SLICE_W];
  end
endmodule

// File: rtl/lane_sub_cutmap.sv
// Marks each slice that begins a lane for the selected width.
module lane_sub_cutmap
  import lane_sub_pkg::*;
#(
  parameter int NSLICE  = 16,
  parameter int SLICE_W = 8
) (
  input  logic [1:0]        width_i,
  output logic [NSLICE-1:0] cut_o
);
  localparam int PER32 = 32 / SLICE_W;
  localparam int PER64 = 64 / SLICE_W;

  lane_w_e w;
  assign w = lane_w_e'(width_i);

  for (genvar i = 0; i < NSLICE; i++) begin : g_cut
    localparam bit AT32 = (i % PER32) == 0;
    localparam bit AT64 = (i % PER64) == 0;
    always_comb begin
      unique case (w)
        LW_32:   cut_o[i] = AT32;
        LW_64:   cut_o[i] = AT64;
        default: cut_o[i] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/lane_sub_sat.sv
// Signed clamp for one byte lane; passes the raw value when disabled.
module lane_sub_sat #(
  parameter int SLICE_W = 8
) (
  input  logic               en_i,
  input  logic               a_sign_i,
  input  logic               b_sign_i,
  input  logic [SLICE_W-1:0] raw_i,
  output logic [SLICE_W-1:0] res_o
);
  localparam logic [SLICE_W-1:0] MAX_POS = {1'b0, {(SLICE_W-1){1'b1}}};
  localparam logic [SLICE_W-1:0] MIN_NEG = {1'b1, {(SLICE_W-1){1'b0}}};

  logic ovf;

  always_comb begin
    ovf   = en_i && (a_sign_i != b_sign_i) && (raw_i[SLICE_W-1] != a_sign_i);
    res_o = ovf ? (a_sign_i ? MIN_NEG : MAX_POS) : raw_i;
  end
endmodule

// File: rtl/lane_sub_unit.sv
module lane_sub_unit
  import lane_sub_pkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int SLICE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        width_i,
  input  logic              sat_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int NSLICE = DATA_W / SLICE_W;

  logic [NSLICE-1:0] cut;
  logic [NSLICE-1:0] bin;
  logic [NSLICE-1:0] bout;
  logic [DATA_W-1:0] raw;
  logic [DATA_W-1:0] clamped;
  logic [DATA_W-1:0] nxt;
  logic              sat_en;
  lane_w_e           w;

  assign w      = lane_w_e'(width_i);
  assign sat_en = sat_i && (w == LW_8);

  lane_sub_cutmap #(.NSLICE(NSLICE), .SLICE_W(SLICE_W)) u_cut (
    .width_i (width_i),
    .cut_o   (cut)
  );

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    localparam int LO = i * SLICE_W;
    localparam int HI = LO + SLICE_W - 1;

    if (i == 0) begin : g_first
      assign bin[i] = 1'b0;
    end else begin : g_rest
      assign bin[i] = cut[i] ? 1'b0 : bout[i-1];
    end

    lane_sub_slice #(.SLICE_W(SLICE_W)) u_sl (
      .a_i    (a_i[HI:LO]),
      .b_i    (b_i[HI:LO]),
      .bin_i  (bin[i]),
      .diff_o (raw[HI:LO]),
      .bout_o (bout[i])
    );

    lane_sub_sat #(.SLICE_W(SLICE_W)) u_sat (
      .en_i     (sat_en),
      .a_sign_i (a_i[HI]),
      .b_sign_i (b_i[HI]),
      .raw_i    (raw[HI:LO]),
      .res_o    (clamped[HI:LO])
    );
  end

  assign nxt = (w == LW_RSV) ? '0 : clamped;

  always_ff @(posedge clk) begin
    if (rst) res_o <= '0;
    else     res_o <= nxt;
  end
endmodule

// File: rtl/lane_sub_unit_chk.sv
module lane_sub_unit_chk #(
  parameter int DATA_W  = 128,
  parameter int SLICE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [1:0]        width_i,
  input logic              sat_i,
  input logic [DATA_W-1:0] res_o
);
  localparam int NSLICE = DATA_W / SLICE_W;

  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (res_o == '0));

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (width_i == 2'b01) |=> (res_o == '0));

  a_r11_equal_zero: assert property (@(posedge clk) disable iff (rst)
    ((width_i != 2'b01) && (a_i == b_i)) |=> (res_o == '0));

  a_r9_sat_ignored_w64: assert property (@(posedge clk) disable iff (rst)
    (sat_i && width_i == 2'b11) |=>
      (res_o[63:0] == 64'($past(a_i[63:0]) - $past(b_i[63:0]))));

  for (genvar i = 0; i < NSLICE; i++) begin : g_lane
    localparam int M = i * SLICE_W + SLICE_W - 1;
    a_r6_pos_clamp_sign: assert property (@(posedge clk) disable iff (rst)
      (sat_i && width_i == 2'b00 && !a_i[M] && b_i[M]) |=> !res_o[M]);
    a_r7_neg_clamp_sign: assert property (@(posedge clk) disable iff (rst)
      (sat_i && width_i == 2'b00 && a_i[M] && !b_i[M]) |=> res_o[M]);
  end
endmodule

bind lane_sub_unit lane_sub_unit_chk #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .a_i     (a_i),
  .b_i     (b_i),
  .width_i (width_i),
  .sat_i   (sat_i),
  .res_o   (res_o)
);

// File: tb/lane_sub_unit_bench.sv
module lane_sub_unit_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] a = '0;
  logic [127:0] b = '0;
  logic [1:0]   wsel = 2'b00;
  logic         sat = 1'b0;
  logic [127:0] res;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  lane_sub_unit u_lane_sub_unit (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b),
    .width_i(wsel), .sat_i(sat), .res_o(res)
  );

  function automatic logic [127:0] model(logic [127:0] x, logic [127:0] y,
                                         logic [1:0] w, logic s);
    logic [127:0] r = '0;
    case (w)
      2'b00: for (int k = 0; k < 16; k++) begin
        int d = int'($signed(x[k*8 +: 8])) - int'($signed(y[k*8 +: 8]));
        if (s && d > 127)  d = 127;
        if (s && d < -128) d = -128;
        r[k*8 +: 8] = d[7:0];
      end
      2'b10: for (int k = 0; k < 4; k++) r[k*32 +: 32] = x[k*32 +: 32] - y[k*32 +: 32];
      2'b11: for (int k = 0; k < 2; k++) r[k*64 +: 64] = x[k*64 +: 64] - y[k*64 +: 64];
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(string tag, logic [127:0] exp);
    total++;
    if (res !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, res, exp);
    end
  endtask

  task automatic run(string tag, logic [127:0] x, logic [127:0] y,
                     logic [1:0] w, logic s);
    @(negedge clk);
    a = x; b = y; wsel = w; sat = s;
    @(negedge clk);
    check(tag, model(x, y, w, s));
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_up();
    end
  end

  initial begin
    a = '1; b = 128'h5; wsel = 2'b10;
    repeat (3) @(negedge clk);
    check("R1 reset", '0);
    rst = 1'b0;

    // R2 and R6 R7 R8: every signed byte pair, 16 pairs per vector
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 4096; i++) begin
        logic [127:0] x, y;
        for (int k = 0; k < 16; k++) begin
          logic [15:0] p = 16'(i * 16 + k);
          x[k*8 +: 8] = p[15:8];
          y[k*8 +: 8] = p[7:0];
        end
        run(s == 0 ? "R2 byte wrap sweep" : "R6 R7 R8 byte sat sweep",
            x, y, 2'b00, s[0]);
      end
    end

    run("R6 clamp high", {16{8'h7F}}, {16{8'h80}}, 2'b00, 1'b1);
    check("R6 value 7F", {16{8'h7F}});
    run("R7 clamp low", {16{8'h80}}, {16{8'h01}}, 2'b00, 1'b1);
    check("R7 value 80", {16{8'h80}});

    // R5: zero minus all-ones gives 1 in every lane
    run("R5 byte", '0, '1, 2'b00, 1'b0);
    check("R5 byte ones", {16{8'h01}});
    run("R5 dword", '0, '1, 2'b10, 1'b0);
    check("R5 dword ones", {4{32'h1}});
    run("R5 qword", '0, '1, 2'b11, 1'b0);
    check("R5 qword ones", {2{64'h1}});

    for (int i = 0; i < 300; i++) run("R3 dword wrap", rnd128(), rnd128(), 2'b10, 1'b0);
    for (int i = 0; i < 300; i++) run("R4 qword wrap", rnd128(), rnd128(), 2'b11, 1'b0);
    run("R3 dword extremes", {4{32'h8000_0000}}, {4{32'h7FFF_FFFF}}, 2'b10, 1'b0);
    run("R4 qword extremes", {2{64'h8000_0000_0000_0000}}, {2{64'h1}}, 2'b11, 1'b0);

    for (int i = 0; i < 200; i++) begin
      logic [127:0] x = rnd128(), y = rnd128();
      run("R9 sat dword", x, y, 2'b10, 1'b1);
      run("R9 sat qword", x, y, 2'b11, 1'b1);
    end
    run("R9 sat dword overflow", {4{32'h7FFF_FFFF}}, {4{32'hFFFF_FFFF}}, 2'b10, 1'b1);
    check("R9 dword wraps", {4{32'h8000_0000}});

    for (int i = 0; i < 50; i++) begin
      run("R10 reserved", rnd128(), rnd128(), 2'b01, i[0]);
      check("R10 zero", '0);
    end

    for (int i = 0; i < 30; i++) begin
      logic [127:0] x = rnd128();
      run("R11 equal byte", x, x, 2'b00, 1'b1);
      run("R11 equal dword", x, x, 2'b10, 1'b0);
      run("R11 equal qword", x, x, 2'b11, 1'b1);
    end

    // R1: reset mid-run clears the registered result
    @(negedge clk);
    a = '1; b = '0; wsel = 2'b11; rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 latency after reset", '1);

    done = 1;
    finish_up();
  end
endmodule